// File: doc/BRIEF.md
# Keyboard/Aux Host Controller Command Engine

This block is the host-facing half of a legacy PC keyboard and auxiliary-device controller. The host reaches it through two byte-wide ports. One is a data port. The other is a command port that reads back as status. The engine decodes controller commands and answers the ones that return a byte. Some commands are two-phase: the command byte is latched, and it decides where the next data-port byte goes. That byte can be passed on to a device, become the mode byte, or be planted in one of the two output holding registers.

Each source has a one-byte holding register with a full flag. The keyboard and aux devices fill these registers from their receive ports, and the controller fills them with its own replies. When both registers are full, the keyboard byte takes priority: it is the byte a data-port read returns, and it governs the output-full status bits and the two interrupt lines. Bytes bound for the devices leave on registered valid/data pulses.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset the mode byte is 0x03, a status read returns 0x18, and both interrupt lines are low.
- R2: Command bytes 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only latch a pending command. The next data-port write is handled by that latch, and the latch then clears. Under 0xD4 the byte appears on the aux transmit port one cycle after the write. Under 0xD1 the byte is consumed with no other effect.
- R3: A data-port write with no pending command appears on the keyboard transmit port, valid for exactly one cycle, on the cycle after the write.
- R4: Command 0x20 loads the current mode byte into the keyboard holding register. A data write under 0x60 replaces the mode byte.
- R5: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4.
- R6: Command 0xAA sets status bit 2, which stays set until reset, and queues 0x55 as keyboard output. Commands 0xA9 and 0xAB queue 0x00, and command 0xC0 queues 0x80.
- R7: Status bit 0 is 1 when either holding register is full. Status bit 5 is 1 only when the aux register is full and the keyboard register is empty. Bits 3 and 4 always read 1. Both bits track the full flags one cycle later.
- R8: irq_kbd is high exactly when the keyboard register is full, mode bit 0 is 1 and mode bit 4 is 0, one cycle after those conditions hold.
- R9: irq_aux is high exactly when only the aux register is full and mode bit 1 is 1, one cycle after that. The two lines are never high together.
- R10: A data-port read returns the aux byte when only the aux register is full, and the keyboard byte otherwise. It clears the full flag of the register it returned. Read data is registered and is valid on the cycle after the read strobe.
- R11: A command byte outside the recognised set changes neither the mode byte, the status byte, the holding registers, nor a pending latched command.
- R12: A receive pulse from the keyboard or aux device loads that source's holding register and sets its full flag. A controller reply written to the same register in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 selects the data port, 1 the command/status port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| kbd_rx_vld | input | 1 | Keyboard device delivers a byte |
| kbd_rx_data | input | 8 | Byte from the keyboard device |
| aux_rx_vld | input | 1 | Aux device delivers a byte |
| aux_rx_data | input | 8 | Byte from the aux device |
| kbd_tx_vld | output | 1 | Byte for the keyboard device is valid |
| kbd_tx_data | output | 8 | Byte for the keyboard device |
| aux_tx_vld | output | 1 | Byte for the aux device is valid |
| aux_tx_data | output | 8 | Byte for the aux device |
| irq_kbd | output | 1 | Keyboard interrupt request |
| irq_aux | output | 1 | Aux interrupt request |

## Verification
The central sweep covers every combination of the three interrupt-related mode bits with all four fill patterns of the two holding registers. This tells keyboard-over-aux priority apart from plain OR logic, and it shows that the disable bit gates only the keyboard line. Directed sequences walk each two-phase command and check that the latch clears after one byte, so a stale route would show up on the wrong transmit port. They also fill both registers through 0xD3 then 0xD2 and drain them, which exposes read-selection and clear-on-read errors. Unknown command bytes are sent both alone and between a latching command and its data byte, to show that no state moves.

// File: rtl/kbc_pkg.sv
`timescale 1ns/1ps
package kbc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  vld;
    byte_t data;
  } push_t;

  // controller command codes (values are fixed by the host software interface)
  localparam byte_t CMD_NONE     = 8'h00;
  localparam byte_t CMD_RD_MODE  = 8'h20;
  localparam byte_t CMD_WR_MODE  = 8'h60;
  localparam byte_t CMD_AUX_OFF  = 8'hA7;
  localparam byte_t CMD_AUX_ON   = 8'hA8;
  localparam byte_t CMD_AUX_TEST = 8'hA9;
  localparam byte_t CMD_SELFTEST = 8'hAA;
  localparam byte_t CMD_KBD_TEST = 8'hAB;
  localparam byte_t CMD_KBD_OFF  = 8'hAD;
  localparam byte_t CMD_KBD_ON   = 8'hAE;
  localparam byte_t CMD_RD_INP   = 8'hC0;
  localparam byte_t CMD_WR_OUTP  = 8'hD1;
  localparam byte_t CMD_LD_KBD   = 8'hD2;
  localparam byte_t CMD_LD_AUX   = 8'hD3;
  localparam byte_t CMD_TO_AUX   = 8'hD4;

  // replies
  localparam byte_t RSP_SELFTEST = 8'h55;
  localparam byte_t RSP_PASS     = 8'h00;
  localparam byte_t RSP_INPORT   = 8'h80;

  // mode bit positions
  localparam int MB_KIRQ = 0;
  localparam int MB_AIRQ = 1;
  localparam int MB_KOFF = 4;
  localparam int MB_AOFF = 5;

  // status bit positions and constants
  localparam int SB_ANY  = 0;
  localparam int SB_TEST = 2;
  localparam int SB_AUXO = 5;
  localparam byte_t MODE_RST   = 8'h03;
  localparam byte_t STAT_FIXED = 8'h18;
endpackage

// File: rtl/kbc_holding.sv
`timescale 1ns/1ps
module kbc_holding #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dev_vld,
  input  logic [DW-1:0] dev_data,
  input  logic          ctl_vld,
  input  logic [DW-1:0] ctl_data,
  input  logic          clr,
  output logic          full,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (ctl_vld) begin
      full <= 1'b1;
      data <= ctl_data;
    end else if (dev_vld) begin
      full <= 1'b1;
      data <= dev_data;
    end else if (clr) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/kbc_decoder.sv
`timescale 1ns/1ps
module kbc_decoder
  import kbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr,
  input  logic  sel,
  input  byte_t wdata,
  output push_t kbd_push,
  output push_t aux_push,
  output logic  kirq_en,
  output logic  airq_en,
  output logic  kbd_off,
  output logic  selftest,
  output logic  kbd_tx_vld,
  output byte_t kbd_tx_data,
  output logic  aux_tx_vld,
  output byte_t aux_tx_data
);
  byte_t mode_q;
  byte_t pend_q;
  logic  st_q;

  wire cmd_wr  = wr && sel;
  wire data_wr = wr && !sel;

  // replies and planted bytes enter the holding registers combinationally
  always_comb begin
    kbd_push = '0;
    aux_push = '0;
    if (cmd_wr) begin
      case (wdata)
        CMD_RD_MODE:               kbd_push = '{vld: 1'b1, data: mode_q};
        CMD_SELFTEST:              kbd_push = '{vld: 1'b1, data: RSP_SELFTEST};
        CMD_AUX_TEST, CMD_KBD_TEST: kbd_push = '{vld: 1'b1, data: RSP_PASS};
        CMD_RD_INP:                kbd_push = '{vld: 1'b1, data: RSP_INPORT};
        default: ;
      endcase
    end else if (data_wr) begin
      case (pend_q)
        CMD_LD_KBD: kbd_push = '{vld: 1'b1, data: wdata};
        CMD_LD_AUX: aux_push = '{vld: 1'b1, data: wdata};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_RST;
      pend_q      <= CMD_NONE;
      st_q        <= 1'b0;
      kbd_tx_vld  <= 1'b0;
      kbd_tx_data <= '0;
      aux_tx_vld  <= 1'b0;
      aux_tx_data <= '0;
    end else begin
      kbd_tx_vld <= 1'b0;
      aux_tx_vld <= 1'b0;
      if (cmd_wr) begin
        case (wdata)
          CMD_WR_MODE, CMD_WR_OUTP, CMD_LD_KBD,
          CMD_LD_AUX, CMD_TO_AUX:  pend_q <= wdata;
          CMD_AUX_OFF:             mode_q[MB_AOFF] <= 1'b1;
          CMD_AUX_ON:              mode_q[MB_AOFF] <= 1'b0;
          CMD_KBD_OFF:             mode_q[MB_KOFF] <= 1'b1;
          CMD_KBD_ON:              mode_q[MB_KOFF] <= 1'b0;
          CMD_SELFTEST:            st_q <= 1'b1;
          default: ;
        endcase
      end else if (data_wr) begin
        case (pend_q)
          CMD_NONE: begin
            kbd_tx_vld  <= 1'b1;
            kbd_tx_data <= wdata;
          end
          CMD_WR_MODE: mode_q <= wdata;
          CMD_TO_AUX: begin
            aux_tx_vld  <= 1'b1;
            aux_tx_data <= wdata;
          end
          default: ;
        endcase
        pend_q <= CMD_NONE;
      end
    end
  end

  assign kirq_en  = mode_q[MB_KIRQ];
  assign airq_en  = mode_q[MB_AIRQ];
  assign kbd_off  = mode_q[MB_KOFF];
  assign selftest = st_q;
endmodule

// File: rtl/kbc_arbiter.sv
`timescale 1ns/1ps
module kbc_arbiter
  import kbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  kbd_full,
  input  logic  aux_full,
  input  byte_t kbd_data,
  input  byte_t aux_data,
  input  logic  kirq_en,
  input  logic  airq_en,
  input  logic  kbd_off,
  input  logic  selftest,
  input  logic  rd,
  input  logic  sel,
  output logic  kbd_clr,
  output logic  aux_clr,
  output byte_t status,
  output byte_t rdata,
  output logic  irq_kbd,
  output logic  irq_aux
);
  logic any_q, auxo_q;

  // keyboard wins whenever it holds data
  wire pick_aux = aux_full && !kbd_full;
  wire data_rd  = rd && !sel;

  assign kbd_clr = data_rd && !pick_aux;
  assign aux_clr = data_rd && pick_aux;

  always_comb begin
    status          = STAT_FIXED;
    status[SB_ANY]  = any_q;
    status[SB_AUXO] = auxo_q;
    status[SB_TEST] = selftest;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_q   <= 1'b0;
      auxo_q  <= 1'b0;
      irq_kbd <= 1'b0;
      irq_aux <= 1'b0;
      rdata   <= '0;
    end else begin
      any_q   <= kbd_full || aux_full;
      auxo_q  <= pick_aux;
      irq_kbd <= kbd_full && kirq_en && !kbd_off;
      irq_aux <= pick_aux && airq_en;
      if (rd) rdata <= sel ? status : (pick_aux ? aux_data : kbd_data);
    end
  end
endmodule

// File: rtl/kbc_cmd_engine.sv
`timescale 1ns/1ps
module kbc_cmd_engine
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       kbd_rx_vld,
  input  logic [7:0] kbd_rx_data,
  input  logic       aux_rx_vld,
  input  logic [7:0] aux_rx_data,
  output logic       kbd_tx_vld,
  output logic [7:0] kbd_tx_data,
  output logic       aux_tx_vld,
  output logic [7:0] aux_tx_data,
  output logic       irq_kbd,
  output logic       irq_aux
);
  push_t kbd_push, aux_push;
  logic  kirq_en, airq_en, kbd_off, selftest;
  logic  kbd_clr, aux_clr, kbd_full, aux_full;
  byte_t kbd_hold, aux_hold, status_w;

  kbc_decoder u_dec (
    .clk(clk), .rst(rst), .wr(host_wr), .sel(host_sel), .wdata(host_wdata),
    .kbd_push(kbd_push), .aux_push(aux_push),
    .kirq_en(kirq_en), .airq_en(airq_en), .kbd_off(kbd_off), .selftest(selftest),
    .kbd_tx_vld(kbd_tx_vld), .kbd_tx_data(kbd_tx_data),
    .aux_tx_vld(aux_tx_vld), .aux_tx_data(aux_tx_data)
  );

  kbc_holding #(.DW(BYTE_W)) u_kbd_hold (
    .clk(clk), .rst(rst), .dev_vld(kbd_rx_vld), .dev_data(kbd_rx_data),
    .ctl_vld(kbd_push.vld), .ctl_data(kbd_push.data), .clr(kbd_clr),
    .full(kbd_full), .data(kbd_hold)
  );

  kbc_holding #(.DW(BYTE_W)) u_aux_hold (
    .clk(clk), .rst(rst), .dev_vld(aux_rx_vld), .dev_data(aux_rx_data),
    .ctl_vld(aux_push.vld), .ctl_data(aux_push.data), .clr(aux_clr),
    .full(aux_full), .data(aux_hold)
  );

  kbc_arbiter u_arb (
    .clk(clk), .rst(rst), .kbd_full(kbd_full), .aux_full(aux_full),
    .kbd_data(kbd_hold), .aux_data(aux_hold),
    .kirq_en(kirq_en), .airq_en(airq_en), .kbd_off(kbd_off), .selftest(selftest),
    .rd(host_rd), .sel(host_sel), .kbd_clr(kbd_clr), .aux_clr(aux_clr),
    .status(status_w), .rdata(host_rdata), .irq_kbd(irq_kbd), .irq_aux(irq_aux)
  );
endmodule

// File: rtl/kbc_cmd_engine_chk.sv
`timescale 1ns/1ps
module kbc_cmd_engine_chk (
  input logic clk,
  input logic rst,
  input logic host_wr,
  input logic host_sel,
  input logic kbd_tx_vld,
  input logic aux_tx_vld,
  input logic irq_kbd,
  input logic irq_aux,
  input logic st_any,
  input logic st_auxo,
  input logic st_test
);
  AST_IRQ_EXCL:    assert property (@(posedge clk) disable iff (rst) !(irq_kbd && irq_aux)); // R9
  AST_AIRQ_AUXO:   assert property (@(posedge clk) disable iff (rst) irq_aux |-> st_auxo); // R9
  AST_KIRQ_OBF:    assert property (@(posedge clk) disable iff (rst) irq_kbd |-> (st_any && !st_auxo)); // R8
  AST_AUXO_ANY:    assert property (@(posedge clk) disable iff (rst) st_auxo |-> st_any); // R7
  AST_KTX_SRC:     assert property (@(posedge clk) disable iff (rst) kbd_tx_vld |-> $past(host_wr && !host_sel)); // R3
  AST_ATX_SRC:     assert property (@(posedge clk) disable iff (rst) aux_tx_vld |-> $past(host_wr && !host_sel)); // R2
  AST_TX_ONE:      assert property (@(posedge clk) disable iff (rst) $onehot0({kbd_tx_vld, aux_tx_vld})); // R2
  AST_TEST_STICKY: assert property (@(posedge clk) disable iff (rst) $past(st_test) |-> st_test); // R6
endmodule

bind kbc_cmd_engine kbc_cmd_engine_chk u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
  .kbd_tx_vld(kbd_tx_vld), .aux_tx_vld(aux_tx_vld),
  .irq_kbd(irq_kbd), .irq_aux(irq_aux),
  .st_any(status_w[0]), .st_auxo(status_w[5]), .st_test(status_w[2])
);

// File: tb/tb_kbc_cmd_engine.sv
`timescale 1ns/1ps
module tb_kbc_cmd_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic kbd_rx_vld = 1'b0, aux_rx_vld = 1'b0;
  logic [7:0] kbd_rx_data = '0, aux_rx_data = '0;
  logic kbd_tx_vld, aux_tx_vld, irq_kbd, irq_aux;
  logic [7:0] kbd_tx_data, aux_tx_data;

  int n_chk = 0, n_fail = 0;
  logic       tk_v, ta_v;
  logic [7:0] tk_d, ta_d;
  logic       st = 1'b0;

  always #2.5 clk = ~clk;

  kbc_cmd_engine dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .kbd_rx_vld(kbd_rx_vld), .kbd_rx_data(kbd_rx_data),
    .aux_rx_vld(aux_rx_vld), .aux_rx_data(aux_rx_data),
    .kbd_tx_vld(kbd_tx_vld), .kbd_tx_data(kbd_tx_data),
    .aux_tx_vld(aux_tx_vld), .aux_tx_data(aux_tx_data),
    .irq_kbd(irq_kbd), .irq_aux(irq_aux)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    tk_v = kbd_tx_vld; tk_d = kbd_tx_data;
    ta_v = aux_tx_vld; ta_d = aux_tx_data;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_sel = s;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic rd_mode(output logic [7:0] d);
    wr(1'b1, 8'h20);
    rd(1'b0, d);
  endtask

  task automatic krx(input logic [7:0] d);
    @(negedge clk);
    kbd_rx_vld = 1'b1; kbd_rx_data = d;
    @(negedge clk);
    kbd_rx_vld = 1'b0;
  endtask

  task automatic arx(input logic [7:0] d);
    @(negedge clk);
    aux_rx_vld = 1'b1; aux_rx_data = d;
    @(negedge clk);
    aux_rx_vld = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();

    // R1 reset state
    chk("R1 irq_kbd", {7'd0, irq_kbd}, 8'h00);
    chk("R1 irq_aux", {7'd0, irq_aux}, 8'h00);
    rd(1'b1, d); chk("R1 status", d, 8'h18);
    rd_mode(d);  chk("R1 mode", d, 8'h03);

    // R3 plain data write goes to keyboard
    wr(1'b0, 8'h9C);
    chk("R3 ktx_v", {7'd0, tk_v}, 8'h01);
    chk("R3 ktx_d", tk_d, 8'h9C);
    chk("R3 atx_v", {7'd0, ta_v}, 8'h00);
    idle(); chk("R3 ktx_pulse", {7'd0, kbd_tx_vld}, 8'h00);

    // R2 two-phase commands
    wr(1'b1, 8'hD4); chk("R2 cmd_no_tx", {6'd0, tk_v, ta_v}, 8'h00);
    wr(1'b0, 8'h5A);
    chk("R2 atx_v", {7'd0, ta_v}, 8'h01);
    chk("R2 atx_d", ta_d, 8'h5A);
    chk("R2 ktx_quiet", {7'd0, tk_v}, 8'h00);
    wr(1'b0, 8'h33);
    chk("R2 latch_cleared", {7'd0, tk_v}, 8'h01);
    chk("R2 latch_cleared_d", tk_d, 8'h33);
    wr(1'b1, 8'hD1); wr(1'b0, 8'hEE);
    chk("R2 outp_drop", {6'd0, tk_v, ta_v}, 8'h00);
    idle(); rd(1'b1, d); chk("R2 outp_status", d, 8'h18);

    // R4 mode write and read
    wr(1'b1, 8'h60); wr(1'b0, 8'h41);
    chk("R4 no_tx", {7'd0, tk_v}, 8'h00);
    rd_mode(d); chk("R4 mode", d, 8'h41);
    wr(1'b1, 8'h60); wr(1'b0, 8'h03);

    // R5 enable/disable bits
    wr(1'b1, 8'hA7); rd_mode(d); chk("R5 aux_off", d, 8'h23);
    wr(1'b1, 8'hA8); rd_mode(d); chk("R5 aux_on", d, 8'h03);
    wr(1'b1, 8'hAD); rd_mode(d); chk("R5 kbd_off", d, 8'h13);
    wr(1'b1, 8'hAE); rd_mode(d); chk("R5 kbd_on", d, 8'h03);

    // R6 test replies
    wr(1'b1, 8'hAA); rd(1'b0, d); chk("R6 selftest", d, 8'h55);
    st = 1'b1;
    idle(); rd(1'b1, d); chk("R6 st_bit", d, 8'h1C);
    wr(1'b1, 8'hA9); rd(1'b0, d); chk("R6 aux_test", d, 8'h00);
    wr(1'b1, 8'hAB); rd(1'b0, d); chk("R6 kbd_test", d, 8'h00);
    wr(1'b1, 8'hC0); rd(1'b0, d); chk("R6 inport", d, 8'h80);
    idle(); rd(1'b1, d); chk("R6 st_sticky", d, 8'h1C);

    // R10 priority read and clear
    wr(1'b1, 8'hD3); wr(1'b0, 8'h77);
    wr(1'b1, 8'hD2); wr(1'b0, 8'h11);
    idle(); rd(1'b1, d); chk("R10 both_status", d, 8'h1D);
    rd(1'b0, d); chk("R10 kbd_first", d, 8'h11);
    idle(); rd(1'b1, d); chk("R10 aux_left", d, 8'h3D);
    chk("R10 irq_aux", {6'd0, irq_kbd, irq_aux}, 8'h01);
    rd(1'b0, d); chk("R10 aux_byte", d, 8'h77);
    idle(); rd(1'b1, d); chk("R10 empty", d, 8'h1C);
    chk("R10 irqs_low", {6'd0, irq_kbd, irq_aux}, 8'h00);

    // R11 unknown commands
    wr(1'b1, 8'h12); wr(1'b1, 8'hFF);
    idle(); rd(1'b1, d); chk("R11 status", d, 8'h1C);
    rd_mode(d); chk("R11 mode", d, 8'h03);
    wr(1'b1, 8'h60); wr(1'b1, 8'h12); wr(1'b0, 8'h05);
    chk("R11 latch_kept", {7'd0, tk_v}, 8'h00);
    rd_mode(d); chk("R11 latch_mode", d, 8'h05);

    // R7 R8 R9 R12 sweep over mode bits and fill patterns
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 4; f++) begin
        logic b0, b1, b4, k, a;
        logic [7:0] mv, es, kb, ab;
        b0 = m[0]; b1 = m[1]; b4 = m[2];
        k = f[1]; a = f[0];
        mv = {3'b000, b4, 2'b00, b1, b0};
        kb = 8'hC0 + 8'(m * 4 + f);
        ab = 8'h40 + 8'(m * 4 + f);
        wr(1'b1, 8'h60); wr(1'b0, mv);
        rd(1'b0, d); rd(1'b0, d);
        if (a) arx(ab);
        if (k) krx(kb);
        idle(); idle();
        chk("R8 irq_kbd", {7'd0, irq_kbd}, {7'd0, k & b0 & ~b4});
        chk("R9 irq_aux", {7'd0, irq_aux}, {7'd0, a & ~k & b1});
        es = 8'h18 | {2'b00, a & ~k, 2'b00, st, 1'b0, k | a};
        rd(1'b1, d); chk("R7 status", d, es);
        if (k | a) begin
          rd(1'b0, d); chk("R12 first_byte", d, k ? kb : ab);
          if (k & a) begin
            idle(); rd(1'b0, d); chk("R12 second_byte", d, ab);
          end
        end
      end
    end
    wr(1'b1, 8'h60); wr(1'b0, 8'h03);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule